// File: doc/BRIEF.md
# One-time-programmable memory mode controller

This block is a cycle-level, synthesizable model of a byte-wide programmable read-only memory that can be erased. A chip-select/program strobe, an output-enable and three condition flags select the operating mode. The flags stand for high voltage on the output-enable pin, high voltage on address bit 9, and the raised supply used while programming. The block can drive a stored byte, float its outputs, merge an input byte into storage, or return a fixed two-byte identification code. Analog levels and real timing margins are not modelled. Access delays are counted in clock cycles.

Storage can only lose ones. A program strobe ANDs the input byte into the addressed location. Only the erase command returns every bit to one. Each falling edge of the chip-select writes exactly once, however long the strobe is held low. Read data is gated by two delay counters. A long counter restarts when the chip is selected or the address changes. A short counter restarts when the output-enable falls.

Top module: `otp_mode_ctrl`

## Requirements
- R1: One cycle after `erase` is high, every location reads 8'hFF.
- R2: `mode` reports 0 for standby, 1 for read, 2 for output disable, 3 for program, 4 for verify, 5 for program inhibit and 6 for identification. High voltage on output-enable takes priority, then chip-select, then output-enable, then identification, then verify.
- R3: In read mode (`ce_n`=0, `oe_n`=0, no flags), once the delays have elapsed, `dout_en`=1 and `dout` equals the stored byte at `addr`.
- R4: With `ce_n`=1 and `vpp_hv`=0 the block is in standby, with `dout_en`=0 and `dout`=0 for either level of `oe_n`.
- R5: With `ce_n`=0, `oe_n`=1 and `vpp_hv`=0 the outputs float (`dout_en`=0, `dout`=0) however long the state is held.
- R6: In program mode (`vpp_hv`=1, `ce_n` falling to 0), the stored byte becomes old AND `din`. Bits can never go from 0 to 1.
- R7: With `vpp_hv`=1 and `ce_n`=1, nothing is written and the outputs float.
- R8: With `vcc_hi`=1 and the read conditions present, the mode is verify and the stored byte is driven as in read.
- R9: With `a9_hv`=1, `ce_n`=`oe_n`=`vpp_hv`=0 and every address bit above bit 0 at zero, `dout` is 8'h8F for `addr[0]`=0 and 8'h85 for `addr[0]`=1.
- R10: `dout_en` rises at the T_ACC-th rising edge after `ce_n` falls or `addr` changes. It also needs the T_OE-th rising edge after `oe_n` falls, with T_OE < T_ACC (defaults 2 and 6).
- R11: A program strobe held low writes only at its falling edge. Later changes of `din` while it stays low have no effect.
- R12: `a9_hv` is ignored when any address bit above bit 0 is nonzero, and the memory byte is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Byte address, AW = clog2(DEPTH) |
| ce_n | input | 1 | Active-low chip select / program strobe |
| oe_n | input | 1 | Active-low output enable |
| vpp_hv | input | 1 | High voltage present on output-enable pin |
| a9_hv | input | 1 | High voltage present on address bit 9 |
| vcc_hi | input | 1 | Programming supply level present |
| erase | input | 1 | Set every bit to one |
| din | input | 8 | Byte to program |
| dout | output | 8 | Driven byte, 0 when floating |
| dout_en | output | 1 | Output driver enable |
| mode | output | 3 | Decoded mode code |

## Verification
Two full programming passes write different address-derived patterns to every location, and then a full sweep reads every location back. A mismatch here means a bit was overwritten instead of ANDed, or that an address bit was aliased. A strobe held low while its data changes separates an edge-triggered write from a level-triggered one. An inhibit attempt with all-zero data shows whether a deselected write leaks into storage. The delay checks sample one cycle before and at the expected edge, for both the output-enable path and the address path. Identification reads at address 0, at address 1 and at an address with upper bits set tell the fixed codes apart from an ordinary memory read.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    MD_STANDBY = 3'd0,
    MD_READ    = 3'd1,
    MD_DISABLE = 3'd2,
    MD_PROGRAM = 3'd3,
    MD_VERIFY  = 3'd4,
    MD_INHIBIT = 3'd5,
    MD_IDENT   = 3'd6
  } otp_mode_e;

  localparam logic [7:0] ID_MAKER  = 8'h8F;
  localparam logic [7:0] ID_DEVICE = 8'h85;
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          vpp_hv,
  input  logic          a9_hv,
  input  logic          vcc_hi,
  output otp_mode_e     mode
);
  logic upper_zero;

  generate
    if (AW > 1) begin : g_upper
      assign upper_zero = (addr[AW-1:1] == '0);
    end else begin : g_single
      assign upper_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    if (vpp_hv) begin
      mode = ce_n ? MD_INHIBIT : MD_PROGRAM;
    end else if (ce_n) begin
      mode = MD_STANDBY;
    end else if (oe_n) begin
      mode = MD_DISABLE;
    end else if (a9_hv && upper_zero) begin
      mode = MD_IDENT;
    end else if (vcc_hi) begin
      mode = MD_VERIFY;
    end else begin
      mode = MD_READ;
    end
  end
endmodule

// File: rtl/otp_access_timer.sv
module otp_access_timer #(
  parameter int LIMIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic restart,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (hold) begin
      cnt_d = '0;
    end else if (restart) begin
      cnt_d = CW'(1);
    end else if (cnt_q != CW'(LIMIT)) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= 8'hFF;
      end
    end else if (wr_en) begin
      mem[addr] <= mem[addr] & wdata;
    end
  end

  assign rdata = mem[addr];

  AST_ERASE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF)); // R1

  AST_AND_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase) |=> ((mem[$past(addr)] & ~$past(mem[addr])) == 8'h00)); // R6
endmodule

// File: rtl/otp_mode_ctrl.sv
module otp_mode_ctrl
  import otp_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int T_ACC = 6,
  parameter int T_OE  = 2,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          vpp_hv,
  input  logic          a9_hv,
  input  logic          vcc_hi,
  input  logic          erase,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_en,
  output logic [2:0]    mode
);
  otp_mode_e  md;
  logic [AW-1:0] addr_q;
  logic       ce_q;
  logic       acc_done, oe_done;
  logic       wr_stb, drive;
  logic [7:0] rdata, sel_data;

  otp_mode_decode #(.AW(AW)) u_decode (
    .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .vpp_hv(vpp_hv),
    .a9_hv(a9_hv), .vcc_hi(vcc_hi), .mode(md)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ce_q   <= 1'b1;
    end else begin
      addr_q <= addr;
      ce_q   <= ce_n;
    end
  end

  otp_access_timer #(.LIMIT(T_ACC)) u_acc_timer (
    .clk(clk), .rst_n(rst_n), .hold(ce_n),
    .restart(addr != addr_q), .done(acc_done)
  );

  otp_access_timer #(.LIMIT(T_OE)) u_oe_timer (
    .clk(clk), .rst_n(rst_n), .hold(oe_n),
    .restart(1'b0), .done(oe_done)
  );

  assign wr_stb = (md == MD_PROGRAM) && ce_q;

  otp_cell_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n), .erase(erase), .wr_en(wr_stb),
    .addr(addr), .wdata(din), .rdata(rdata)
  );

  always_comb begin
    drive = (md == MD_READ) || (md == MD_VERIFY) || (md == MD_IDENT);
    if (md == MD_IDENT) begin
      sel_data = addr[0] ? ID_DEVICE : ID_MAKER;
    end else begin
      sel_data = rdata;
    end
  end

  assign dout_en = drive && acc_done && oe_done && (addr == addr_q);
  assign dout    = dout_en ? sel_data : 8'h00;
  assign mode    = md;

  AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en); // R4

  AST_HV_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_hv |-> !dout_en); // R7

  AST_OE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> !dout_en); // R10

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R11
endmodule

// File: tb/otp_mode_ctrl_tb_top.sv
module otp_mode_ctrl_tb_top;
  localparam int DEPTH = 256;
  localparam int AW    = 8;
  localparam int T_ACC = 6;
  localparam int T_OE  = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          ce_n, oe_n, vpp_hv, a9_hv, vcc_hi, erase;
  logic [7:0]    din;
  logic [7:0]    dout;
  logic          dout_en;
  logic [2:0]    mode;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  otp_mode_ctrl #(.DEPTH(DEPTH), .T_ACC(T_ACC), .T_OE(T_OE)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .vpp_hv(vpp_hv), .a9_hv(a9_hv), .vcc_hi(vcc_hi), .erase(erase),
    .din(din), .dout(dout), .dout_en(dout_en), .mode(mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat_a(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] pat_b(input int a);
    return ~8'(a * 3);
  endfunction

  task automatic do_erase();
    @(negedge clk); erase = 1'b1;
    @(negedge clk); erase = 1'b0;
  endtask

  task automatic prog(input int a, input logic [7:0] d);
    @(negedge clk); addr = AW'(a); din = d; vpp_hv = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); vpp_hv = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string req);
    @(negedge clk); addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0;
    repeat (T_ACC) @(negedge clk);
    chk(req, {dout_en, dout}, {1'b1, 8'(exp)});
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected <150000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; ce_n = 1'b1; oe_n = 1'b1; vpp_hv = 1'b0;
    a9_hv = 1'b0; vcc_hi = 1'b0; erase = 1'b0; din = 8'h00;
    repeat (3) @(negedge clk);
    chk("R2 reset mode", mode, 0);
    chk("R4 reset float", {dout_en, dout}, 0);
    rst_n = 1'b1;

    // R1: erase then sweep for all ones
    do_erase();
    for (int a = 0; a < DEPTH; a++) rd(a, 8'hFF, "R1 erased");

    // R6 / R3: two programming passes, AND result read back
    for (int a = 0; a < DEPTH; a++) prog(a, pat_a(a));
    for (int a = 0; a < DEPTH; a++) prog(a, pat_b(a));
    for (int a = 0; a < DEPTH; a++) rd(a, pat_a(a) & pat_b(a), "R6 R3 and-merge");

    // R11: strobe held low, data changed mid-pulse
    do_erase();
    @(negedge clk); addr = 8'd10; din = 8'hF0; vpp_hv = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); chk("R2 program mode", mode, 3); din = 8'h0F;
    repeat (3) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk); vpp_hv = 1'b0;
    rd(10, 8'hF0, "R11 single write");

    // R7: inhibit with zero data
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; vpp_hv = 1'b1; din = 8'h00; addr = 8'd10;
    repeat (3) @(negedge clk);
    chk("R7 inhibit mode", mode, 5);
    chk("R7 inhibit float", {dout_en, dout}, 0);
    @(negedge clk); vpp_hv = 1'b0;
    rd(10, 8'hF0, "R7 no write");
    rd(11, 8'hFF, "R7 neighbour");

    // R5: output disable
    @(negedge clk); oe_n = 1'b1;
    repeat (T_ACC + 2) @(negedge clk);
    chk("R2 disable mode", mode, 2);
    chk("R5 disable float", {dout_en, dout}, 0);

    // R10: output-enable path
    oe_n = 1'b0;
    repeat (T_OE - 1) @(negedge clk);
    chk("R10 oe early", dout_en, 0);
    @(negedge clk);
    chk("R10 oe on time", {dout_en, dout}, {1'b1, 8'hFF});

    // R10: address path
    addr = 8'd10;
    repeat (T_ACC - 1) @(negedge clk);
    chk("R10 addr early", dout_en, 0);
    @(negedge clk);
    chk("R10 addr on time", {dout_en, dout}, {1'b1, 8'hF0});
    chk("R2 read mode", mode, 1);

    // R4: standby with oe low and high
    ce_n = 1'b1;
    @(negedge clk);
    chk("R2 standby mode", mode, 0);
    chk("R4 standby oe low", {dout_en, dout}, 0);
    oe_n = 1'b1;
    @(negedge clk);
    chk("R4 standby oe high", {dout_en, dout}, 0);

    // R8: verify
    vcc_hi = 1'b1;
    rd(10, 8'hF0, "R8 verify data");
    chk("R8 verify mode", mode, 4);
    vcc_hi = 1'b0;

    // R9 / R12: identification
    a9_hv = 1'b1;
    rd(0, 8'h8F, "R9 maker code");
    chk("R9 ident mode", mode, 6);
    rd(1, 8'h85, "R9 device code");
    rd(10, 8'hF0, "R12 a9 ignored");
    chk("R12 read mode", mode, 1);
    a9_hv = 1'b0;
    rd(1, 8'hFF, "R9 normal read addr1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule